// File: doc/BRIEF.md
# Constant-Rate Fixed-Address Cell Segmenter

This block turns a host-filled memory FIFO into a stream of fixed-size cells at a rate set by an external scheduler. The FIFO is reached at a single fixed address. Every read of that address returns the next payload byte. For each transmit opportunity, the block sends a 4-byte header word held in a host register. It then sends 48 payload bytes, each fetched with its own read request to the FIFO address. There are no descriptors, no queue of buffers and no completion reports. Cells keep coming for as long as the channel runs.

The host first programs the FIFO address and the header with the run bit low. It fills its FIFO and then raises run. When the FIFO runs low, the host sets a skip request. The block then gives up exactly one transmit opportunity and clears the request by itself. Opportunities that arrive while a cell is still going out are counted in a saturating missed-slot counter.

Top module: `cbr_fifo_segmenter`

## Requirements
- R1: After reset no cell byte is presented, no read is requested, the missed-slot counter is zero, and run and skip read back as zero.
- R2: While run is low, transmit opportunities start no cell, issue no read and leave the missed-slot counter unchanged.
- R3: Each cell is exactly 52 bytes on a byte-wide stream with a valid flag; the last flag is high on the 52nd byte only.
- R4: The first 4 bytes of a cell are the header register captured at the accepted opportunity, bits 31:24 first and bits 7:0 fourth.
- R5: Bytes 5 to 52 are the FIFO read data in return order. Each is fetched by a one-cycle read request carrying the programmed FIFO address, and no new request is made before the previous one returns.
- R6: With run high and no skip pending, every opportunity that arrives while no cell is in progress starts a new cell, without limit.
- R7: An opportunity that arrives with run high, skip pending and no cell in progress produces no cell and clears the skip bit.
- R8: A host write to the control register in the same cycle that a skip is consumed sets the new skip value from the write data.
- R9: An opportunity arriving while a cell is in progress is dropped and increments the missed-slot counter, which saturates at its all-ones value.
- R10: Host register select 0 is control (bit 0 run, bit 1 skip), select 1 is the FIFO address, select 2 is the header word; writes take effect on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| reg_we_i | input | 1 | Host register write strobe |
| reg_sel_i | input | 2 | Host register select |
| reg_wdata_i | input | 32 | Host write data |
| run_o | output | 1 | Current run bit |
| skip_o | output | 1 | Current skip-request bit |
| slot_i | input | 1 | Transmit-opportunity strobe from the scheduler |
| rd_req_o | output | 1 | FIFO byte read request |
| rd_addr_o | output | ADDR_W | Fixed FIFO address |
| rd_valid_i | input | 1 | Read data returned |
| rd_data_i | input | 8 | Returned FIFO byte |
| cell_valid_o | output | 1 | Cell byte valid |
| cell_data_o | output | 8 | Cell byte |
| cell_last_o | output | 1 | Final byte of a cell |
| missed_o | output | MISS_W | Saturating count of missed opportunities |

## Verification
The hardest case to reach is a host write to the control register that lands in the same cycle as the opportunity that consumes a pending skip. The bench arms the skip first. It then drives the scheduler strobe and a control write with skip set on the same falling edge. After that it checks that skip is still pending and that no cell went out. Missed-slot saturation is also hard to reach. The bench holds the strobe high for about a hundred cycles inside each of three cells, which pushes the counter past its limit.

// File: rtl/cbr_seg_pkg.sv
package cbr_seg_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_REQ, ST_WAIT} cell_st_e;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_ADDR = 2'd1;
    localparam logic [1:0] SEL_HDR  = 2'd2;

    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_SKIP_BIT = 1;
    localparam int REG_W         = 32;
endpackage

// File: rtl/cbr_seg_regs.sv
module cbr_seg_regs
    import cbr_seg_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int HDR_W  = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [1:0]        sel_i,
    input  logic [REG_W-1:0]  wdata_i,
    input  logic              skip_taken_i,
    output logic              run_o,
    output logic              skip_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [HDR_W-1:0]  hdr_o
);
    typedef struct packed {
        logic              run;
        logic              skip;
        logic [ADDR_W-1:0] addr;
        logic [HDR_W-1:0]  hdr;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        // block clear first, so a same-cycle host write overrides it
        if (skip_taken_i) r_d.skip = 1'b0;
        if (we_i) begin
            unique case (sel_i)
                SEL_CTRL: begin
                    r_d.run  = wdata_i[CTRL_RUN_BIT];
                    r_d.skip = wdata_i[CTRL_SKIP_BIT];
                end
                SEL_ADDR: r_d.addr = wdata_i[ADDR_W-1:0];
                SEL_HDR:  r_d.hdr  = wdata_i[HDR_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign run_o  = r_q.run;
    assign skip_o = r_q.skip;
    assign addr_o = r_q.addr;
    assign hdr_o  = r_q.hdr;
endmodule

// File: rtl/cbr_seg_cell_fsm.sv
module cbr_seg_cell_fsm
    import cbr_seg_pkg::*;
#(
    parameter int HDR_BYTES = 4,
    parameter int PAY_BYTES = 48
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   slot_i,
    input  logic                   run_i,
    input  logic                   skip_i,
    input  logic [HDR_BYTES*8-1:0] hdr_i,
    input  logic                   rd_valid_i,
    input  logic [7:0]             rd_data_i,
    output logic                   rd_req_o,
    output logic                   skip_taken_o,
    output logic                   miss_o,
    output logic                   busy_o,
    output logic                   cell_valid_o,
    output logic [7:0]             cell_data_o,
    output logic                   cell_last_o
);
    localparam int HDR_W  = HDR_BYTES * 8;
    localparam int MAXB   = (PAY_BYTES > HDR_BYTES) ? PAY_BYTES : HDR_BYTES;
    localparam int IDX_W  = $clog2(MAXB) + 1;
    localparam logic [IDX_W-1:0] HDR_END = IDX_W'(HDR_BYTES - 1);
    localparam logic [IDX_W-1:0] PAY_END = IDX_W'(PAY_BYTES - 1);

    typedef struct packed {
        cell_st_e         st;
        logic [IDX_W-1:0] idx;
        logic [HDR_W-1:0] hdr;
        logic             ovld;
        logic [7:0]       odata;
        logic             olast;
    } fsm_t;

    fsm_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.ovld     = 1'b0;
        s_d.olast    = 1'b0;
        rd_req_o     = 1'b0;
        skip_taken_o = 1'b0;
        miss_o       = slot_i && (s_q.st != ST_IDLE);
        unique case (s_q.st)
            ST_IDLE: begin
                if (slot_i && run_i) begin
                    if (skip_i) begin
                        skip_taken_o = 1'b1;
                    end else begin
                        s_d.st  = ST_HDR;
                        s_d.idx = '0;
                        s_d.hdr = hdr_i;
                    end
                end
            end
            ST_HDR: begin
                s_d.ovld  = 1'b1;
                s_d.odata = s_q.hdr[HDR_W-1 -: 8];
                s_d.hdr   = s_q.hdr << 8;
                s_d.idx   = s_q.idx + 1'b1;
                if (s_q.idx == HDR_END) begin
                    s_d.st  = ST_REQ;
                    s_d.idx = '0;
                end
            end
            ST_REQ: begin
                rd_req_o = 1'b1;
                s_d.st   = ST_WAIT;
            end
            ST_WAIT: begin
                if (rd_valid_i) begin
                    s_d.ovld  = 1'b1;
                    s_d.odata = rd_data_i;
                    if (s_q.idx == PAY_END) begin
                        s_d.olast = 1'b1;
                        s_d.idx   = '0;
                        s_d.st    = ST_IDLE;
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                        s_d.st  = ST_REQ;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '{st: ST_IDLE, default: '0};
        else         s_q <= s_d;
    end

    assign busy_o       = (s_q.st != ST_IDLE);
    assign cell_valid_o = s_q.ovld;
    assign cell_data_o  = s_q.odata;
    assign cell_last_o  = s_q.olast;
endmodule

// File: rtl/cbr_seg_miss_cnt.sv
module cbr_seg_miss_cnt #(
    parameter int MISS_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              inc_i,
    output logic [MISS_W-1:0] cnt_o
);
    typedef struct packed {
        logic [MISS_W-1:0] cnt;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (inc_i && (c_q.cnt != '1)) c_d.cnt = c_q.cnt + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) c_q <= '0;
        else         c_q <= c_d;
    end

    assign cnt_o = c_q.cnt;
endmodule

// File: rtl/cbr_fifo_segmenter.sv
module cbr_fifo_segmenter
    import cbr_seg_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int HDR_BYTES = 4,
    parameter int PAY_BYTES = 48,
    parameter int MISS_W    = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              reg_we_i,
    input  logic [1:0]        reg_sel_i,
    input  logic [31:0]       reg_wdata_i,
    output logic              run_o,
    output logic              skip_o,
    input  logic              slot_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_valid_i,
    input  logic [7:0]        rd_data_i,
    output logic              cell_valid_o,
    output logic [7:0]        cell_data_o,
    output logic              cell_last_o,
    output logic [MISS_W-1:0] missed_o
);
    localparam int HDR_W = HDR_BYTES * 8;

    logic             skip_taken;
    logic             miss;
    logic             busy;
    logic [HDR_W-1:0] hdr;

    cbr_seg_regs #(.ADDR_W(ADDR_W), .HDR_W(HDR_W)) regs_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .we_i         (reg_we_i),
        .sel_i        (reg_sel_i),
        .wdata_i      (reg_wdata_i),
        .skip_taken_i (skip_taken),
        .run_o        (run_o),
        .skip_o       (skip_o),
        .addr_o       (rd_addr_o),
        .hdr_o        (hdr)
    );

    cbr_seg_cell_fsm #(.HDR_BYTES(HDR_BYTES), .PAY_BYTES(PAY_BYTES)) fsm_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .slot_i       (slot_i),
        .run_i        (run_o),
        .skip_i       (skip_o),
        .hdr_i        (hdr),
        .rd_valid_i   (rd_valid_i),
        .rd_data_i    (rd_data_i),
        .rd_req_o     (rd_req_o),
        .skip_taken_o (skip_taken),
        .miss_o       (miss),
        .busy_o       (busy),
        .cell_valid_o (cell_valid_o),
        .cell_data_o  (cell_data_o),
        .cell_last_o  (cell_last_o)
    );

    cbr_seg_miss_cnt #(.MISS_W(MISS_W)) miss_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .inc_i  (miss),
        .cnt_o  (missed_o)
    );
endmodule

// File: rtl/cbr_seg_chk.sv
module cbr_seg_chk #(
    parameter int MISS_W     = 8,
    parameter int CELL_BYTES = 52
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              slot_i,
    input logic              run_i,
    input logic              skip_i,
    input logic              busy_i,
    input logic              ctrl_wr_i,
    input logic              wr_skip_i,
    input logic              rd_req_i,
    input logic              cell_valid_i,
    input logic              cell_last_i,
    input logic [MISS_W-1:0] missed_i
);
    localparam int CNT_W = $clog2(CELL_BYTES) + 1;
    logic [CNT_W-1:0] byte_cnt;

    always_ff @(posedge clk_i) begin
        if (!rst_ni)               byte_cnt <= '0;
        else if (cell_valid_i)     byte_cnt <= cell_last_i ? '0 : byte_cnt + 1'b1;
    end

    assert_idle_stopped_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_i && !busy_i) |=> (!cell_valid_i && !rd_req_i));
    assert_stopped_no_miss_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_i && !busy_i) |=> $stable(missed_i));
    assert_last_at_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cell_last_i |-> (cell_valid_i && byte_cnt == CNT_W'(CELL_BYTES - 1)));
    assert_len_ends_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cell_valid_i && byte_cnt == CNT_W'(CELL_BYTES - 1)) |-> cell_last_i);
    assert_single_req_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_req_i |=> !rd_req_i);
    assert_skip_consumed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (slot_i && run_i && skip_i && !busy_i && !ctrl_wr_i) |=> (!skip_i && !cell_valid_i));
    assert_host_write_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (slot_i && run_i && skip_i && !busy_i && ctrl_wr_i) |=> (skip_i == $past(wr_skip_i)));
    assert_miss_inc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (slot_i && busy_i && missed_i != '1) |=> (missed_i == $past(missed_i) + 1'b1));
    assert_miss_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(slot_i && busy_i) |=> $stable(missed_i));
endmodule

bind cbr_fifo_segmenter cbr_seg_chk #(.MISS_W(MISS_W), .CELL_BYTES(HDR_BYTES + PAY_BYTES)) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .slot_i       (slot_i),
    .run_i        (run_o),
    .skip_i       (skip_o),
    .busy_i       (busy),
    .ctrl_wr_i    (reg_we_i && (reg_sel_i == cbr_seg_pkg::SEL_CTRL)),
    .wr_skip_i    (reg_wdata_i[cbr_seg_pkg::CTRL_SKIP_BIT]),
    .rd_req_i     (rd_req_o),
    .cell_valid_i (cell_valid_o),
    .cell_last_i  (cell_last_o),
    .missed_i     (missed_o)
);

// File: tb/cbr_fifo_segmenter_tb_top.sv
module cbr_fifo_segmenter_tb_top;
    localparam int ADDR_W = 32;
    localparam int MISS_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_we = 1'b0;
    logic [1:0]        reg_sel = '0;
    logic [31:0]       reg_wdata = '0;
    logic              run, skip;
    logic              slot = 1'b0;
    logic              rd_req;
    logic [ADDR_W-1:0] rd_addr;
    logic              rd_valid;
    logic [7:0]        rd_data;
    logic              cvld, clast;
    logic [7:0]        cdata;
    logic [MISS_W-1:0] missed;

    always #2.5 clk = ~clk;

    cbr_fifo_segmenter #(.ADDR_W(ADDR_W), .MISS_W(MISS_W)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
        .reg_wdata_i(reg_wdata), .run_o(run), .skip_o(skip), .slot_i(slot),
        .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_valid_i(rd_valid),
        .rd_data_i(rd_data), .cell_valid_o(cvld), .cell_data_o(cdata),
        .cell_last_o(clast), .missed_o(missed)
    );

    int total = 0;
    int bad = 0;
    int bytes_seen = 0;
    logic [31:0] cfg_addr = '0;
    logic [31:0] cfg_hdr = '0;
    logic [7:0]  exp_seq = '0;
    logic [8:0]  exp_q[$];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // FIFO memory model: two-cycle return, each read pops the next byte
    logic       pend1 = 1'b0;
    logic [7:0] mem_seq = '0;
    always @(posedge clk) begin
        if (!rst_n) begin
            pend1 <= 1'b0; rd_valid <= 1'b0; rd_data <= '0; mem_seq <= '0;
        end else begin
            if (rd_req) chk(rd_addr == cfg_addr, "R5 read address", rd_addr, cfg_addr);
            pend1    <= rd_req;
            rd_valid <= pend1;
            rd_data  <= mem_seq;
            if (pend1) mem_seq <= mem_seq + 8'd1;
        end
    end

    // monitor: pop expected bytes as the design produces them
    always @(negedge clk) begin
        if (rst_n && cvld) begin
            bytes_seen++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2/R7 unexpected cell byte", {23'd0, clast, cdata}, 32'h0);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                chk({clast, cdata} == e, "R3/R4/R5 cell byte", {23'd0, clast, cdata}, {23'd0, e});
            end
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        if (sel == 2'd1) cfg_addr = d;
        if (sel == 2'd2) cfg_hdr = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic push_cell();
        for (int i = 0; i < 4; i++) exp_q.push_back({1'b0, cfg_hdr[31 - 8*i -: 8]});
        for (int i = 0; i < 48; i++) begin
            exp_q.push_back({(i == 47), exp_seq});
            exp_seq = exp_seq + 8'd1;
        end
    endtask

    task automatic give_slot(input bit expect_cell);
        @(negedge clk);
        slot = 1'b1;
        if (expect_cell) push_cell();
        @(negedge clk);
        slot = 1'b0;
    endtask

    task automatic wait_done();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 32'd0, 32'd1);
        finish_up();
    end

    initial begin
        int seen;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cvld == 1'b0, "R1 cell_valid", cvld, 0);
        chk(rd_req == 1'b0, "R1 rd_req", rd_req, 0);
        chk(missed == 0, "R1 missed", missed, 0);
        chk(run == 1'b0 && skip == 1'b0, "R1 run/skip", {run, skip}, 0);
        rst_n = 1'b1;
        wr(2'd1, 32'hA000_0040);
        wr(2'd2, 32'hDEAD_BEEF);

        // R2 stopped channel ignores opportunities
        seen = bytes_seen;
        repeat (3) give_slot(1'b0);
        repeat (30) @(negedge clk);
        chk(bytes_seen == seen, "R2 no cell while stopped", bytes_seen, seen);
        chk(missed == 0, "R2 missed unchanged", missed, 0);

        // R10 control register fields
        wr(2'd0, 32'h1);
        chk(run == 1'b1 && skip == 1'b0, "R10 ctrl write", {run, skip}, 2'b10);

        // R3 R4 R5 first cell
        give_slot(1'b1);
        wait_done();
        chk(bytes_seen == seen + 52, "R3 cell length", bytes_seen, seen + 52);

        // R9 slot during a cell is dropped and counted
        give_slot(1'b1);
        repeat (10) @(negedge clk);
        give_slot(1'b0);
        wait_done();
        chk(missed == 1, "R9 missed count", missed, 1);

        // R4 new header on following cell
        wr(2'd2, 32'h0102_0304);
        give_slot(1'b1);
        wait_done();

        // R7 skip gives up exactly one opportunity
        wr(2'd0, 32'h3);
        chk(skip == 1'b1, "R10 skip set", skip, 1);
        seen = bytes_seen;
        give_slot(1'b0);
        chk(skip == 1'b0, "R7 skip cleared", skip, 0);
        repeat (40) @(negedge clk);
        chk(bytes_seen == seen, "R7 no cell on skip", bytes_seen, seen);
        give_slot(1'b1);
        wait_done();

        // R8 host write in the consuming cycle is retained
        wr(2'd0, 32'h3);
        seen = bytes_seen;
        @(negedge clk);
        slot = 1'b1; reg_we = 1'b1; reg_sel = 2'd0; reg_wdata = 32'h3;
        @(negedge clk);
        slot = 1'b0; reg_we = 1'b0;
        chk(skip == 1'b1, "R8 skip retained", skip, 1);
        repeat (40) @(negedge clk);
        chk(bytes_seen == seen, "R8 no cell", bytes_seen, seen);
        give_slot(1'b0);
        chk(skip == 1'b0, "R8 second skip consumed", skip, 0);
        give_slot(1'b1);
        wait_done();

        // R6 back-to-back cells
        seen = bytes_seen;
        for (int c = 0; c < 5; c++) begin
            give_slot(1'b1);
            wait_done();
        end
        chk(bytes_seen == seen + 5*52, "R6 continuous cells", bytes_seen, seen + 5*52);

        // R9 saturation
        for (int c = 0; c < 3; c++) begin
            give_slot(1'b1);
            @(negedge clk);
            slot = 1'b1;
            repeat (100) @(negedge clk);
            slot = 1'b0;
            wait_done();
        end
        chk(missed == 8'hFF, "R9 saturation", missed, 8'hFF);
        chk(exp_q.size() == 0, "R3 all bytes delivered", exp_q.size(), 0);
        finish_up();
    end
endmodule